// File: doc/BRIEF.md
# Flash Lock-Bit Command Controller

This block is the command front end and sequencer that look after the write-protection bits of a flash-style memory. There is one protect bit for each erase block and one device-wide permanent protect bit. A host writes command bytes on a simple bus with a write strobe, an address and a data byte, and it reads bytes back with a read strobe. Each protection change needs two writes: a setup byte, then a confirm byte. The confirm byte selects one of three operations: protect one block, protect the whole device for good, or drop every block protect bit together.

A valid confirm starts a timed busy interval of `BUSY_CYCLES` clocks, during which `ready` is low. When the interval ends, the block applies the result. The result is either the requested change or a set of sticky error flags in a status byte. The host sees the status byte on every read after a lock sequence until it asks for array reads again. An input flag reports that the programming voltage is too low. The address is the block index.

Reset is synchronous and active high. It models the device reset pin and not a power cycle, so the stored protect bits survive it. The one exception is a reset that lands in the middle of a clear-all. That leaves the block bits at an unspecified, X-free value and raises a flag that asks for the clear to be repeated.

Top module: `lockbit_cmd_ctrl`

## Requirements
- R1: A lock operation needs a setup write of 0x60 followed directly by a confirm write. No protect bit changes and `ready` stays high until the confirm arrives.
- R2: Confirm byte 0x01 protects the block whose index is on `addr` in the confirm cycle. Only that bit of `lock_bits` changes.
- R3: Confirm byte 0xF1 sets `perm_lock` whatever the confirm address is. Once set, `perm_lock` never returns to 0, through any command or through reset.
- R4: Confirm byte 0xD0 clears every bit of `lock_bits` in the same cycle.
- R5: After a lock sequence, and after 0x70, every read returns the status byte until 0xFF is written. In array mode a read returns `{6'b0, perm_lock, lock_bits[addr]}`. The status byte layout is: bit7 ready, bit5 clear error, bit4 set error, bit3 low-voltage error, bit1 permanent-protect error, and every other bit 0.
- R6: `ready` goes low in the cycle after a valid confirm and stays low for exactly `BUSY_CYCLES` cycles. Status bit 7 always equals `ready`.
- R7: A setup write followed by any byte other than 0x01, 0xF1 or 0xD0 sets status bits 5 and 4. It does not start a busy interval and changes no protect bit.
- R8: With `perm_lock` set, a block-protect attempt fails with status bits 1 and 4 set, and a clear-all attempt fails with status bits 1 and 5 set. Neither attempt changes `lock_bits`.
- R9: With `vpp_low` high at the confirm, a clear-all sets status bits 3 and 5, and a block-protect or permanent-protect attempt sets status bits 3 and 4. No protect bit changes.
- R10: The error bits are sticky. Only writing 0x50 clears them. Writing 0xFF or 0x70 leaves them as they are.
- R11: While `ready` is low, every write is ignored: it changes neither the read mode nor any protect bit.
- R12: A reset during a clear-all leaves `lock_bits` at an X-free value and sets `needs_reclear`. A clear-all that completes clears the flag. A reset at any other time keeps `lock_bits` and `perm_lock`, clears the error bits and returns the controller to array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (device reset pin) |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; `rdata` is 0 when this is low |
| addr | input | ADDR_W | Block index for confirms and array reads |
| wdata | input | 8 | Command byte |
| vpp_low | input | 1 | Programming voltage below the usable level |
| rdata | output | 8 | Status byte or array-mode protect info |
| ready | output | 1 | 1 when idle, 0 during the busy interval |
| lock_bits | output | NUM_BLOCKS | Per-block protect bits |
| perm_lock | output | 1 | Permanent protect bit |
| needs_reclear | output | 1 | Block bits are undefined until a clear-all completes |

## Verification
The hardest case to reach from the ports is a reset that falls inside the busy interval of a clear-all. The bench first protects a block, then writes the clear sequence and counts down from the confirm. It raises `rst` for a single cycle while `ready` is still low. After that it checks the recovery flag and that the bits are X-free, then shows that a repeated clear-all returns the bits to zero. The permanent-protect paths are irreversible, so they are exercised last, after every other sweep.

// File: rtl/lkc_pkg.sv
package lkc_pkg;

    localparam logic [7:0] OPC_LOCK_SETUP  = 8'h60;
    localparam logic [7:0] OPC_CONF_BLOCK  = 8'h01;
    localparam logic [7:0] OPC_CONF_PERM   = 8'hF1;
    localparam logic [7:0] OPC_CONF_CLEAR  = 8'hD0;
    localparam logic [7:0] OPC_CLR_STATUS  = 8'h50;
    localparam logic [7:0] OPC_READ_STATUS = 8'h70;
    localparam logic [7:0] OPC_READ_ARRAY  = 8'hFF;

    typedef enum logic [1:0] {
        MODE_ARRAY,
        MODE_STATUS,
        MODE_SETUP
    } mode_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SET_BLOCK,
        OP_SET_PERM,
        OP_CLEAR_ALL
    } op_e;

    typedef struct packed {
        logic perm_err;
        logic vpp_err;
        logic set_err;
        logic clr_err;
    } err_t;

    typedef struct packed {
        logic ok;
        err_t err;
    } outcome_t;

    // Map a byte written in setup mode to the operation it confirms.
    function automatic op_e lkc_confirm_op(logic [7:0] d);
        case (d)
            OPC_CONF_BLOCK: return OP_SET_BLOCK;
            OPC_CONF_PERM:  return OP_SET_PERM;
            OPC_CONF_CLEAR: return OP_CLEAR_ALL;
            default:        return OP_NONE;
        endcase
    endfunction

    // Decide the outcome of a finished operation; low voltage is checked first.
    function automatic outcome_t lkc_judge(op_e op, logic vpp_low, logic perm);
        outcome_t r;
        r = '0;
        case (op)
            OP_SET_BLOCK: begin
                if (vpp_low)   begin r.err.vpp_err  = 1'b1; r.err.set_err = 1'b1; end
                else if (perm) begin r.err.perm_err = 1'b1; r.err.set_err = 1'b1; end
                else           r.ok = 1'b1;
            end
            OP_SET_PERM: begin
                if (vpp_low) begin r.err.vpp_err = 1'b1; r.err.set_err = 1'b1; end
                else         r.ok = 1'b1;
            end
            OP_CLEAR_ALL: begin
                if (vpp_low)   begin r.err.vpp_err  = 1'b1; r.err.clr_err = 1'b1; end
                else if (perm) begin r.err.perm_err = 1'b1; r.err.clr_err = 1'b1; end
                else           r.ok = 1'b1;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] lkc_status_byte(logic rdy, err_t e);
        return {rdy, 1'b0, e.clr_err, e.set_err, e.vpp_err, 1'b0, e.perm_err, 1'b0};
    endfunction

endpackage

// File: rtl/lkc_cui.sv
module lkc_cui
    import lkc_pkg::*;
#(
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    input  logic [BLK_W-1:0] addr,
    input  logic             busy,
    output mode_e            mode,
    output logic             start,
    output op_e              start_op,
    output logic [BLK_W-1:0] start_blk,
    output logic             invalid,
    output logic             clr_status
);

    mode_e mode_q;
    logic  accept;
    op_e   conf_op;

    assign accept    = wr_en && !busy;
    assign conf_op   = lkc_confirm_op(wdata);
    assign start     = accept && (mode_q == MODE_SETUP) && (conf_op != OP_NONE);
    assign invalid   = accept && (mode_q == MODE_SETUP) && (conf_op == OP_NONE);
    assign clr_status = accept && (mode_q != MODE_SETUP) && (wdata == OPC_CLR_STATUS);
    assign start_op  = conf_op;
    assign start_blk = addr;
    assign mode      = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_ARRAY;
        end else if (accept) begin
            if (mode_q == MODE_SETUP) begin
                mode_q <= MODE_STATUS;
            end else begin
                case (wdata)
                    OPC_LOCK_SETUP:  mode_q <= MODE_SETUP;
                    OPC_READ_STATUS: mode_q <= MODE_STATUS;
                    OPC_READ_ARRAY:  mode_q <= MODE_ARRAY;
                    default:         mode_q <= mode_q;
                endcase
            end
        end
    end

    // R11: the read mode cannot move while an operation runs
    a_r11_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_q));

    // R1: a confirm is only taken straight after a setup
    a_r1_setup_then_confirm: assert property (@(posedge clk) disable iff (rst)
        start |=> (mode_q == MODE_STATUS));

endmodule

// File: rtl/lkc_wsm.sv
module lkc_wsm
    import lkc_pkg::*;
#(
    parameter int BUSY_CYCLES = 8,
    parameter int BLK_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  op_e              start_op,
    input  logic [BLK_W-1:0] start_blk,
    input  logic             vpp_low,
    output logic             busy,
    output logic             done,
    output op_e              cur_op,
    output logic [BLK_W-1:0] cur_blk,
    output logic             cur_vpp_low,
    output logic             abort_clear
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    op_e              op_q;
    logic [BLK_W-1:0] blk_q;
    logic             vpp_q;

    assign busy        = busy_q;
    assign done        = busy_q && (cnt_q == '0);
    assign cur_op      = op_q;
    assign cur_blk     = blk_q;
    assign cur_vpp_low = vpp_q;
    assign abort_clear = rst && busy_q && (op_q == OP_CLEAR_ALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_NONE;
            blk_q  <= '0;
            vpp_q  <= 1'b0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LOAD;
            op_q   <= start_op;
            blk_q  <= start_blk;
            vpp_q  <= vpp_low;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R6: the countdown never exceeds its load value
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q <= CNT_LOAD));

    // R11: the decoder never starts an operation while one runs
    a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !start);

    // R6: a start always opens a busy interval with a valid operation
    a_r6_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy_q && op_q != OP_NONE));

endmodule

// File: rtl/lkc_lockstore.sv
module lkc_lockstore
    import lkc_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int BLK_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  abort_clear,
    input  logic                  apply,
    input  op_e                   op,
    input  logic [BLK_W-1:0]      blk,
    input  logic                  ok,
    output logic [NUM_BLOCKS-1:0] lock_bits,
    output logic                  perm_lock,
    output logic                  needs_reclear
);

    // Non-volatile content: power-up value only, not touched by the reset pin.
    logic [NUM_BLOCKS-1:0] lock_q   = '0;
    logic                  perm_q   = 1'b0;
    logic                  reclr_q  = 1'b0;
    logic [NUM_BLOCKS-1:0] lock_d;

    logic do_clear;
    logic do_set;
    logic do_perm;

    assign do_clear = apply && ok && (op == OP_CLEAR_ALL);
    assign do_set   = apply && ok && (op == OP_SET_BLOCK);
    assign do_perm  = apply && ok && (op == OP_SET_PERM);

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_bit
        // An interrupted clear leaves each bit in the protected state.
        assign lock_d[i] = abort_clear ? 1'b1 :
                           do_clear    ? 1'b0 :
                           (do_set && blk == BLK_W'(i)) ? 1'b1 : lock_q[i];
    end

    always_ff @(posedge clk) begin
        lock_q <= lock_d;
        if (do_perm) begin
            perm_q <= 1'b1;
        end
        if (abort_clear) begin
            reclr_q <= 1'b1;
        end else if (do_clear) begin
            reclr_q <= 1'b0;
        end
    end

    assign lock_bits     = lock_q;
    assign perm_lock     = perm_q;
    assign needs_reclear = reclr_q;

    // R3: the permanent bit never drops
    a_r3_perm_sticky: assert property (@(posedge clk) disable iff (rst)
        perm_q |=> perm_q);

    // R1: without a finished operation the block bits hold
    a_r1_bits_hold: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(lock_q));

    // R2: a block set raises at most one bit
    a_r2_single_bit: assert property (@(posedge clk) disable iff (rst)
        do_set |=> ($countones(lock_q ^ $past(lock_q)) <= 1));

endmodule

// File: rtl/lockbit_cmd_ctrl.sv
module lockbit_cmd_ctrl
    import lkc_pkg::*;
#(
    parameter  int NUM_BLOCKS  = 16,
    parameter  int BUSY_CYCLES = 8,
    localparam int ADDR_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [7:0]            wdata,
    input  logic                  vpp_low,
    output logic [7:0]            rdata,
    output logic                  ready,
    output logic [NUM_BLOCKS-1:0] lock_bits,
    output logic                  perm_lock,
    output logic                  needs_reclear
);

    mode_e            mode;
    logic             start;
    op_e              start_op;
    logic [ADDR_W-1:0] start_blk;
    logic             invalid;
    logic             clr_status;
    logic             busy;
    logic             done;
    op_e              cur_op;
    logic [ADDR_W-1:0] cur_blk;
    logic             cur_vpp_low;
    logic             abort_clear;
    outcome_t         outcome;
    err_t             err_q;
    logic [7:0]       status;

    lkc_cui #(.BLK_W(ADDR_W)) u_cui (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wdata      (wdata),
        .addr       (addr),
        .busy       (busy),
        .mode       (mode),
        .start      (start),
        .start_op   (start_op),
        .start_blk  (start_blk),
        .invalid    (invalid),
        .clr_status (clr_status)
    );

    lkc_wsm #(.BUSY_CYCLES(BUSY_CYCLES), .BLK_W(ADDR_W)) u_wsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_op    (start_op),
        .start_blk   (start_blk),
        .vpp_low     (vpp_low),
        .busy        (busy),
        .done        (done),
        .cur_op      (cur_op),
        .cur_blk     (cur_blk),
        .cur_vpp_low (cur_vpp_low),
        .abort_clear (abort_clear)
    );

    assign outcome = lkc_judge(cur_op, cur_vpp_low, perm_lock);

    lkc_lockstore #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(ADDR_W)) u_store (
        .clk           (clk),
        .rst           (rst),
        .abort_clear   (abort_clear),
        .apply         (done),
        .op            (cur_op),
        .blk           (cur_blk),
        .ok            (outcome.ok),
        .lock_bits     (lock_bits),
        .perm_lock     (perm_lock),
        .needs_reclear (needs_reclear)
    );

    always_ff @(posedge clk) begin
        if (rst || clr_status) begin
            err_q <= '0;
        end else if (invalid) begin
            err_q.set_err <= 1'b1;
            err_q.clr_err <= 1'b1;
        end else if (done) begin
            err_q <= err_q | outcome.err;
        end
    end

    assign ready  = !busy;
    assign status = lkc_status_byte(ready, err_q);

    always_comb begin
        if (!rd_en) begin
            rdata = 8'h00;
        end else if (mode == MODE_ARRAY) begin
            rdata = {6'b0, perm_lock, lock_bits[addr]};
        end else begin
            rdata = status;
        end
    end

    // R7: a bad confirm flags both bits and starts nothing
    a_r7_invalid_flags: assert property (@(posedge clk) disable iff (rst)
        invalid |=> (err_q.set_err && err_q.clr_err && ready));

    // R8: protect attempt against a permanently locked device
    a_r8_perm_blocks_set: assert property (@(posedge clk) disable iff (rst)
        (done && cur_op == OP_SET_BLOCK && !cur_vpp_low && perm_lock)
        |=> (err_q.perm_err && err_q.set_err && $stable(lock_bits)));

    // R9: clear attempted at low programming voltage
    a_r9_vpp_clear: assert property (@(posedge clk) disable iff (rst)
        (done && cur_op == OP_CLEAR_ALL && cur_vpp_low)
        |=> (err_q.vpp_err && err_q.clr_err && $stable(lock_bits)));

    // R4: a successful clear empties every block bit
    a_r4_clear_all: assert property (@(posedge clk) disable iff (rst)
        (done && cur_op == OP_CLEAR_ALL && !cur_vpp_low && !perm_lock)
        |=> (lock_bits == '0 && !needs_reclear));

    // R10: error flags only drop on the clear-status command
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_status |=> ((err_q & $past(err_q)) == $past(err_q)));

endmodule

// File: tb/tb_lockbit_cmd_ctrl.sv
module tb_lockbit_cmd_ctrl;

    localparam int NB  = 8;
    localparam int BC  = 5;
    localparam int AW  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          vpp_low = 1'b0;
    logic [7:0]    rdata;
    logic          ready;
    logic [NB-1:0] lock_bits;
    logic          perm_lock;
    logic          needs_reclear;

    lockbit_cmd_ctrl #(.NUM_BLOCKS(NB), .BUSY_CYCLES(BC)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .vpp_low(vpp_low), .rdata(rdata), .ready(ready),
        .lock_bits(lock_bits), .perm_lock(perm_lock), .needs_reclear(needs_reclear)
    );

    always #2 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [NB-1:0] e_lock = '0;
    logic e_perm = 0, e_clr = 0, e_set = 0, e_vpp = 0, e_pe = 0;

    function automatic logic [7:0] exp_status();
        return 8'h80 | (e_clr ? 8'h20 : 8'h00) | (e_set ? 8'h10 : 8'h00)
                     | (e_vpp ? 8'h08 : 8'h00) | (e_pe ? 8'h02 : 8'h00);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        #1;
        v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic wait_ready(output int cnt);
        cnt = 0;
        while (ready == 1'b0 && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic lock_op(input logic [AW-1:0] a, input logic [7:0] conf, input string req);
        int c;
        wr('0, 8'h60);
        wr(a, conf);
        wait_ready(c);
        chk(req, c, BC);
    endtask

    task automatic clr_stat();
        wr('0, 8'h50);
        e_clr = 0; e_set = 0; e_vpp = 0; e_pe = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        chk("R6 ready after reset", ready, 1);
        chk("R12 bits after reset", lock_bits, 0);
        chk("R3 perm after reset", perm_lock, 0);
        rd(0, v); chk("R5 array read after reset", v, 8'h00);

        // R1: setup alone changes nothing and does not go busy
        wr(3, 8'h60);
        chk("R1 no busy on setup", ready, 1);
        chk("R1 no change on setup", lock_bits, 0);
        rd(3, v); chk("R5 setup mode reads status", v, exp_status());
        wr(3, 8'h01);
        chk("R6 busy after confirm", ready, 0);
        rd(5, v); chk("R6 status bit7 low when busy", v, 8'h00);
        wait_ready(c);
        chk("R6 busy length", c, BC);
        e_lock[3] = 1'b1;
        chk("R2 block 3 set", lock_bits, e_lock);

        // R2 sweep over every block
        for (int b = 0; b < NB; b++) begin
            lock_op(AW'(b), 8'h01, "R6 busy length sweep");
            e_lock[b] = 1'b1;
            chk("R2 sweep lock bits", lock_bits, e_lock);
            rd(AW'((b + 5) % NB), v);
            chk("R5 status after sequence", v, exp_status());
        end

        // R5 array mode after 0xFF
        wr(0, 8'hFF);
        for (int a = 0; a < NB; a++) begin
            rd(AW'(a), v);
            chk("R5 array read", v, {6'b0, e_perm, e_lock[a]});
        end

        // R4 clear all
        lock_op(0, 8'hD0, "R6 busy length clear");
        e_lock = '0;
        chk("R4 all cleared", lock_bits, e_lock);

        // R11 writes during busy are ignored
        wr(0, 8'h60);
        wr(6, 8'h01);
        wr(0, 8'hFF);
        wr(0, 8'h60);
        wr(2, 8'h01);
        wait_ready(c);
        e_lock[6] = 1'b1;
        chk("R11 only first op applied", lock_bits, e_lock);
        rd(0, v); chk("R11 mode kept status", v, exp_status());

        // R7 invalid pair
        wr(0, 8'h60);
        wr(1, 8'h33);
        chk("R7 no busy", ready, 1);
        e_clr = 1; e_set = 1;
        rd(0, v); chk("R7 status bits", v, exp_status());
        chk("R7 no change", lock_bits, e_lock);

        // R10 sticky across 0xFF and 0x70
        wr(0, 8'hFF);
        wr(0, 8'h70);
        rd(0, v); chk("R10 sticky errors", v, exp_status());
        clr_stat();
        rd(0, v); chk("R10 clear status", v, 8'h80);

        // R9 low voltage cases
        vpp_low = 1'b1;
        lock_op(0, 8'hD0, "R9 busy clear");
        e_vpp = 1; e_clr = 1;
        rd(0, v); chk("R9 clear low vpp status", v, exp_status());
        chk("R9 clear low vpp no change", lock_bits, e_lock);
        clr_stat();
        lock_op(1, 8'h01, "R9 busy set");
        e_vpp = 1; e_set = 1;
        rd(0, v); chk("R9 set low vpp status", v, exp_status());
        chk("R9 set low vpp no change", lock_bits, e_lock);
        clr_stat();
        lock_op(4, 8'hF1, "R9 busy perm");
        e_vpp = 1; e_set = 1;
        rd(0, v); chk("R9 perm low vpp status", v, exp_status());
        chk("R9 perm low vpp no change", perm_lock, 0);
        vpp_low = 1'b0;

        // R12 reset while idle keeps bits, clears errors, array mode
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        e_clr = 0; e_set = 0; e_vpp = 0; e_pe = 0;
        chk("R12 reset keeps bits", lock_bits, e_lock);
        rd(6, v); chk("R12 reset array mode", v, 8'h01);
        wr(0, 8'h70);
        rd(0, v); chk("R12 reset cleared errors", v, 8'h80);

        // R12 reset during clear
        wr(0, 8'h60);
        wr(0, 8'hD0);
        @(negedge clk);
        chk("R12 still busy", ready, 0);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R12 reclear flag", needs_reclear, 1);
        chk("R12 bits known", $isunknown(lock_bits), 0);
        chk("R12 ready after abort", ready, 1);
        lock_op(0, 8'hD0, "R12 busy reclear");
        e_lock = '0;
        chk("R12 reclear bits", lock_bits, 0);
        chk("R12 reclear flag dropped", needs_reclear, 0);

        // R3 permanent lock, any address
        lock_op(2, 8'h01, "R2 busy pre perm");
        e_lock[2] = 1'b1;
        lock_op(7, 8'hF1, "R3 busy perm");
        e_perm = 1;
        chk("R3 perm set", perm_lock, 1);

        // R8 with permanent lock
        lock_op(5, 8'h01, "R8 busy set");
        e_pe = 1; e_set = 1;
        rd(0, v); chk("R8 set blocked status", v, exp_status());
        chk("R8 set blocked bits", lock_bits, e_lock);
        clr_stat();
        lock_op(0, 8'hD0, "R8 busy clear");
        e_pe = 1; e_clr = 1;
        rd(0, v); chk("R8 clear blocked status", v, exp_status());
        chk("R8 clear blocked bits", lock_bits, e_lock);
        clr_stat();

        // R3 survives reset and array read shows it
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R3 perm after reset", perm_lock, 1);
        rd(2, v); chk("R5 array read with perm", v, 8'h03);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule